// File: doc/BRIEF.md
# Stereo Noise Gate Gain Controller

This block sits in front of a headphone volume stage and decides the attenuation code that is actually applied to the output. It watches the signed left and right samples taken ahead of the volume control. When the programme material stays quiet for long enough, it lowers the gain by a programmed depth. When the signal comes back, it raises the gain again. The attenuation written by the user is only an input: the block never changes it. The value that is really applied lives in a separate internal register and appears on `eff_att`.

The controller is a five-state machine. The states are IDLE (0), HOLD (1), ATTACK (2), GATED (3) and RELEASE (4).

- **IDLE → HOLD:** a quiet sample arrives.
- **HOLD → ATTACK:** the quiet run has lasted the hold time.
- **HOLD → IDLE:** a loud sample arrives.
- **ATTACK → GATED:** the applied code has reached its goal.
- **ATTACK → RELEASE** and **GATED → RELEASE:** a loud sample arrives.
- **GATED → ATTACK:** the goal moves while the input is still quiet.
- **RELEASE → IDLE:** the applied code is back at the user setting.

Attack and release each move the code one step per programmed number of clock cycles. The two rates are set separately. A mono mode restricts the quiet test to the left channel.

Top module: `ng_gain_ctrl`

## Requirements
- R1: While `rst_n` is low, `gate_state` is 0 (IDLE) and `eff_att` is 0.
- R2: In IDLE and HOLD, `eff_att` equals the `user_att` value sampled on the previous clock edge.
- R3: The amplitude of a sample is its absolute value, so the most negative code has the largest amplitude. The input counts as quiet only when the left and right amplitudes are both strictly below `thresh`. An amplitude equal to `thresh` is loud.
- R4: When `mono` is 1, only the left amplitude decides quiet. The right sample has no effect.
- R5: `gate_state` uses these codes: 0 IDLE, 1 HOLD, 2 ATTACK, 3 GATED, 4 RELEASE. With `hold_cycles` = H, ATTACK is entered on the edge that takes the (H+1)-th consecutive quiet sample. A loud sample in HOLD returns the state to IDLE and restarts the count. ATTACK can be entered only from HOLD or GATED.
- R6: In ATTACK, `eff_att` moves by exactly 1 toward the goal. The first step comes on the P-th edge after entering the state, and later steps every P edges, where P = `attack_cycles` (0 acts as 1). The goal is `user_att + gate_depth`.
- R7: The goal is clamped to the largest attenuation code (2^ATT_W − 1). `eff_att` never wraps.
- R8: When `eff_att` equals the goal during ATTACK, the next edge enters GATED. In GATED, `eff_att` holds.
- R9: A loud sample in ATTACK or GATED moves the state to RELEASE on the next edge.
- R10: In RELEASE, `eff_att` moves by 1 toward `user_att` once every `release_cycles` edges, with the first step P edges after entry. Once equal to `user_att`, the next edge enters IDLE. Quiet samples during RELEASE do not re-engage the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mono | input | 1 | 1: only the left channel decides quiet |
| left_smp | input | SAMPLE_W | Signed left sample before the volume stage |
| right_smp | input | SAMPLE_W | Signed right sample before the volume stage |
| user_att | input | ATT_W | User attenuation setting |
| thresh | input | SAMPLE_W | Quiet threshold on the absolute amplitude |
| gate_depth | input | ATT_W | Extra attenuation applied while gated |
| hold_cycles | input | HOLD_W | Quiet run required before attacking |
| attack_cycles | input | RATE_W | Clock cycles per attack step |
| release_cycles | input | RATE_W | Clock cycles per release step |
| eff_att | output | ATT_W | Attenuation code actually applied |
| gate_state | output | 3 | Current state code (see R5) |

## Verification
The hardest situation to create from the ports is the GATED state with the clamp active. To get there, the bench must hold a quiet pattern for the whole hold time, then keep it through every attack step until the applied code stops at the top code. The bench drives the same quiet sample for a precomputed number of edges and checks the state and the code on the exact edges the rates predict. It then breaks the quiet run with a single loud sample to walk the release back down to IDLE. Boundary amplitudes are covered by a vector table: a sample equal to the threshold, the most negative sample code, and mono with a loud right channel.

// File: rtl/ng_pkg.sv
`timescale 1ns/1ps
package ng_pkg;
    typedef enum logic [2:0] {
        NG_IDLE    = 3'd0,
        NG_HOLD    = 3'd1,
        NG_ATTACK  = 3'd2,
        NG_GATED   = 3'd3,
        NG_RELEASE = 3'd4
    } ng_state_e;
endpackage

// File: rtl/ng_level_detect.sv
`timescale 1ns/1ps
module ng_level_detect #(
    parameter int SAMPLE_W = 16,
    parameter int NCH      = 2
) (
    input  logic [NCH-1:0][SAMPLE_W-1:0] smp,
    input  logic [SAMPLE_W-1:0]          thresh,
    input  logic                         mono,
    output logic                         quiet
);
    logic [NCH-1:0] below;

    genvar ch;
    generate
        for (ch = 0; ch < NCH; ch++) begin : g_chan
            logic [SAMPLE_W-1:0] mag;
            // absolute value; the most negative code maps to 2^(W-1), which fits unsigned
            assign mag       = smp[ch][SAMPLE_W-1] ? (~smp[ch] + 1'b1) : smp[ch];
            assign below[ch] = (mag < thresh);
        end
    endgenerate

    // mono: channel 0 (left) alone decides
    assign quiet = mono ? below[0] : (&below);
endmodule

// File: rtl/ng_rate_timer.sv
`timescale 1ns/1ps
module ng_rate_timer #(
    parameter int RATE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    input  logic [RATE_W-1:0] period,
    output logic              tick
);
    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W:0]   cnt_nx;

    assign cnt_nx = {1'b0, cnt_q} + 1'b1;
    // a zero period behaves as a period of one
    assign tick   = run && (cnt_nx >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run || tick) cnt_q <= '0;
        else                                cnt_q <= cnt_nx[RATE_W-1:0];
    end
endmodule

// File: rtl/ng_gate_fsm.sv
`timescale 1ns/1ps
module ng_gate_fsm
    import ng_pkg::*;
#(
    parameter int ATT_W  = 6,
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              quiet,
    input  logic              tick,
    input  logic [ATT_W-1:0]  user_att,
    input  logic [ATT_W-1:0]  gate_depth,
    input  logic [HOLD_W-1:0] hold_cycles,
    output ng_state_e         state_q,
    output logic              state_chg,
    output logic [ATT_W-1:0]  eff_q
);
    localparam int               ATT_MAX   = (1 << ATT_W) - 1;
    localparam logic [ATT_W:0]   ATT_MAX_X = (ATT_W+1)'(ATT_MAX);

    ng_state_e         state_d;
    logic [HOLD_W-1:0] hold_q;
    logic [ATT_W:0]    goal_sum;
    logic [ATT_W-1:0]  goal;

    assign goal_sum  = {1'b0, user_att} + {1'b0, gate_depth};
    assign goal      = (goal_sum > ATT_MAX_X) ? ATT_MAX_X[ATT_W-1:0] : goal_sum[ATT_W-1:0];
    assign state_chg = (state_d != state_q);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NG_IDLE:    if (quiet) state_d = NG_HOLD;
            NG_HOLD: begin
                if (!quiet)                    state_d = NG_IDLE;
                else if (hold_q >= hold_cycles) state_d = NG_ATTACK;
            end
            NG_ATTACK: begin
                if (!quiet)             state_d = NG_RELEASE;
                else if (eff_q == goal) state_d = NG_GATED;
            end
            NG_GATED: begin
                if (!quiet)             state_d = NG_RELEASE;
                else if (eff_q != goal) state_d = NG_ATTACK;
            end
            NG_RELEASE: if (eff_q == user_att) state_d = NG_IDLE;
            default:    state_d = NG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= NG_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers: hold counter and applied attenuation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            eff_q  <= '0;
        end else begin
            unique case (state_q)
                NG_IDLE: begin
                    hold_q <= quiet ? HOLD_W'(1) : '0;
                    eff_q  <= user_att;
                end
                NG_HOLD: begin
                    if (!quiet)                    hold_q <= '0;
                    else if (hold_q < hold_cycles) hold_q <= hold_q + 1'b1;
                    eff_q <= user_att;
                end
                NG_ATTACK: begin
                    hold_q <= '0;
                    if (quiet && tick && (eff_q != goal))
                        eff_q <= (eff_q < goal) ? eff_q + 1'b1 : eff_q - 1'b1;
                end
                NG_GATED: hold_q <= '0;
                NG_RELEASE: begin
                    hold_q <= '0;
                    if (tick && (eff_q != user_att))
                        eff_q <= (eff_q > user_att) ? eff_q - 1'b1 : eff_q + 1'b1;
                end
                default: begin
                    hold_q <= '0;
                    eff_q  <= user_att;
                end
            endcase
        end
    end
endmodule

// File: rtl/ng_gain_ctrl.sv
`timescale 1ns/1ps
module ng_gain_ctrl
    import ng_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ATT_W    = 6,
    parameter int HOLD_W   = 16,
    parameter int RATE_W   = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mono,
    input  logic signed [SAMPLE_W-1:0] left_smp,
    input  logic signed [SAMPLE_W-1:0] right_smp,
    input  logic [ATT_W-1:0]           user_att,
    input  logic [SAMPLE_W-1:0]        thresh,
    input  logic [ATT_W-1:0]           gate_depth,
    input  logic [HOLD_W-1:0]          hold_cycles,
    input  logic [RATE_W-1:0]          attack_cycles,
    input  logic [RATE_W-1:0]          release_cycles,
    output logic [ATT_W-1:0]           eff_att,
    output logic [2:0]                 gate_state
);
    localparam int NCH = 2;

    logic [NCH-1:0][SAMPLE_W-1:0] smp_bus;
    logic                         quiet_w;
    logic                         tick_w;
    logic                         chg_w;
    logic                         rate_run;
    logic [RATE_W-1:0]            rate_period;
    ng_state_e                    st_w;

    assign smp_bus = {right_smp, left_smp};

    ng_level_detect #(.SAMPLE_W(SAMPLE_W), .NCH(NCH)) u_det (
        .smp    (smp_bus),
        .thresh (thresh),
        .mono   (mono),
        .quiet  (quiet_w)
    );

    assign rate_run    = (st_w == NG_ATTACK) || (st_w == NG_RELEASE);
    assign rate_period = (st_w == NG_ATTACK) ? attack_cycles : release_cycles;

    ng_rate_timer #(.RATE_W(RATE_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (rate_run),
        .clr    (chg_w),
        .period (rate_period),
        .tick   (tick_w)
    );

    ng_gate_fsm #(.ATT_W(ATT_W), .HOLD_W(HOLD_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .quiet       (quiet_w),
        .tick        (tick_w),
        .user_att    (user_att),
        .gate_depth  (gate_depth),
        .hold_cycles (hold_cycles),
        .state_q     (st_w),
        .state_chg   (chg_w),
        .eff_q       (eff_att)
    );

    assign gate_state = st_w;
endmodule

// File: rtl/ng_gain_chk.sv
`timescale 1ns/1ps
module ng_gain_chk #(
    parameter int ATT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             quiet,
    input logic [2:0]       gate_state,
    input logic [ATT_W-1:0] eff_att,
    input logic [ATT_W-1:0] user_att,
    input logic [ATT_W-1:0] gate_depth
);
    localparam int             ATT_MAX   = (1 << ATT_W) - 1;
    localparam logic [ATT_W:0] ATT_MAX_X = (ATT_W+1)'(ATT_MAX);

    logic [ATT_W:0]   chk_sum;
    logic [ATT_W-1:0] chk_goal;
    assign chk_sum  = {1'b0, user_att} + {1'b0, gate_depth};
    assign chk_goal = (chk_sum > ATT_MAX_X) ? ATT_MAX_X[ATT_W-1:0] : chk_sum[ATT_W-1:0];

    assert_legal_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gate_state <= 3'd4);

    assert_tracks_user_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(gate_state) == 3'd0 || $past(gate_state) == 3'd1))
        |-> eff_att == $past(user_att));

    assert_unit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(gate_state) == 3'd2 || $past(gate_state) == 3'd4))
        |-> ({1'b0, eff_att} == {1'b0, $past(eff_att)} ||
             {1'b0, eff_att} == {1'b0, $past(eff_att)} + 1'b1 ||
             {1'b0, eff_att} + 1'b1 == {1'b0, $past(eff_att)}));

    assert_loud_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_state == 3'd2 || gate_state == 3'd3) && !quiet) |=> gate_state == 3'd4);

    assert_engage_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && gate_state == 3'd2 && $past(gate_state) != 3'd2)
        |-> ($past(gate_state) == 3'd1 || $past(gate_state) == 3'd3));

    assert_gated_goal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && gate_state == 3'd3 && $past(gate_state) == 3'd2 &&
         $stable(user_att) && $stable(gate_depth))
        |-> eff_att == chk_goal);
endmodule

bind ng_gain_ctrl ng_gain_chk #(.ATT_W(ATT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .quiet      (quiet_w),
    .gate_state (gate_state),
    .eff_att    (eff_att),
    .user_att   (user_att),
    .gate_depth (gate_depth)
);

// File: tb/tb_ng_gain_ctrl.sv
`timescale 1ns/1ps
module tb_ng_gain_ctrl;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               mono = 1'b0;
    logic signed [15:0] left_smp = '0;
    logic signed [15:0] right_smp = '0;
    logic [5:0]         user_att = '0;
    logic [15:0]        thresh = 16'd100;
    logic [5:0]         gate_depth = 6'd5;
    logic [15:0]        hold_cycles = 16'd2;
    logic [11:0]        attack_cycles = 12'd1000;
    logic [11:0]        release_cycles = 12'd1000;
    logic [5:0]         eff_att;
    logic [2:0]         gate_state;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ng_gain_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mono(mono), .left_smp(left_smp),
        .right_smp(right_smp), .user_att(user_att), .thresh(thresh),
        .gate_depth(gate_depth), .hold_cycles(hold_cycles),
        .attack_cycles(attack_cycles), .release_cycles(release_cycles),
        .eff_att(eff_att), .gate_state(gate_state)
    );

    // mono | left | right | thresh | expected state after 3 edges
    localparam int NV = 9;
    localparam logic [51:0] VECS [NV] = '{
        {1'b0,  16'sd50,    -16'sd50,   16'd100,   3'd2},
        {1'b0,  16'sd100,   16'sd0,     16'd100,   3'd0},
        {1'b0,  16'sd0,     -16'sd100,  16'd100,   3'd0},
        {1'b0,  -16'sd99,   16'sd99,    16'd100,   3'd2},
        {1'b1,  16'sd10,    16'sd30000, 16'd100,   3'd2},
        {1'b1,  -16'sd200,  16'sd0,     16'd100,   3'd0},
        {1'b0,  16'h8000,   16'sd0,     16'd100,   3'd0},
        {1'b0,  16'sd0,     16'sd0,     16'd0,     3'd0},
        {1'b0,  16'h8000,   16'h8000,   16'hFFFF,  3'd2}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic loud();
        left_smp = 16'sd5000; right_smp = 16'sd5000;
    endtask

    task automatic hush();
        left_smp = 16'sd3; right_smp = -16'sd3;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        loud();
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        // R1: reset state
        mono = 1'b0; user_att = 6'd10; loud();
        tick(2);
        chk("R1 state", gate_state, 0);
        chk("R1 eff_att", eff_att, 0);
        rst_n = 1'b1;

        // R2: applied value follows user setting one edge later
        tick(1);
        chk("R2 follow", eff_att, 10);
        user_att = 6'd20;
        tick(1);
        chk("R2 follow new", eff_att, 20);

        // table: R3 / R4 quiet decision
        for (int i = 0; i < NV; i++) begin
            do_reset();
            user_att = 6'd10; gate_depth = 6'd5; hold_cycles = 16'd2;
            attack_cycles = 12'd1000; release_cycles = 12'd1000;
            mono = VECS[i][51]; left_smp = VECS[i][50:35];
            right_smp = VECS[i][34:19]; thresh = VECS[i][18:3];
            tick(3);
            chk(VECS[i][51] ? "R4 mono vector" : "R3 stereo vector",
                gate_state, int'(VECS[i][2:0]));
        end
        mono = 1'b0; thresh = 16'd100;

        // R5: hold restart on a loud sample
        do_reset();
        hush(); tick(2);
        chk("R5 holding", gate_state, 1);
        loud(); tick(1);
        chk("R5 restart", gate_state, 0);
        hush(); tick(2);
        chk("R5 hold again", gate_state, 1);
        tick(1);
        chk("R5 engage", gate_state, 2);

        // R6 / R8 / R10 full cycle: user 10, depth 5, attack 4, release 3
        do_reset();
        user_att = 6'd10; gate_depth = 6'd5; attack_cycles = 12'd4; release_cycles = 12'd3;
        tick(1);
        hush(); tick(3);
        chk("R5 attack entry", gate_state, 2);
        tick(3);
        chk("R6 no step yet", eff_att, 10);
        tick(1);
        chk("R6 first step", eff_att, 11);
        tick(16);
        chk("R6 at goal", eff_att, 15);
        chk("R6 still attack", gate_state, 2);
        tick(1);
        chk("R8 gated", gate_state, 3);
        tick(10);
        chk("R8 gated hold", eff_att, 15);
        loud(); tick(1);
        chk("R9 release", gate_state, 4);
        hush(); tick(3);
        chk("R10 first down step", eff_att, 14);
        tick(12);
        chk("R10 back to user", eff_att, 10);
        chk("R10 quiet ignored", gate_state, 4);
        tick(1);
        chk("R10 idle", gate_state, 0);

        // R9: loud during attack
        do_reset();
        user_att = 6'd10; attack_cycles = 12'd4; release_cycles = 12'd3;
        tick(1);
        hush(); tick(3);
        tick(4);
        chk("R6 step before abort", eff_att, 11);
        loud(); tick(1);
        chk("R9 abort attack", gate_state, 4);
        tick(3);
        chk("R10 abort down", eff_att, 10);
        tick(1);
        chk("R10 abort idle", gate_state, 0);

        // R7: clamp at the top code
        do_reset();
        user_att = 6'd60; gate_depth = 6'd10; attack_cycles = 12'd1;
        tick(1);
        hush(); tick(3);
        chk("R7 attack entry", gate_state, 2);
        tick(10);
        chk("R7 clamped", eff_att, 63);
        chk("R7 gated", gate_state, 3);

        summary();
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule